// File: doc/BRIEF.md
# Banked Floating-Point Register File

This block holds the floating-point working registers of a processor core. It has thirty-two 32-bit storage words in two physical banks of sixteen. A single swap bit decides which bank is seen as the front set (FR0..FR15) and which is seen as the extended set (XF0..XF15). Arithmetic units read operands through one combinational read port and return results through one write port. Each port names a logical set, an access size and a register index. One access moves one word, an aligned pair (64 bits) or an aligned group of four (128 bits).

The whole extended set is also driven out at all times as a 16-word matrix view, for units that work on a full matrix. A separate 32-bit transfer register carries values between the integer side and the float side. The integer side loads it directly, and the float side can capture the low word currently on the read port. The block stores and routes data only. It does no arithmetic and no rounding.

Top module: `fpr_bank_file`

## Requirements
- R1: With the swap bit at 0, the front set (set select 0) maps to physical bank 0 and the extended set (set select 1) maps to bank 1. With the swap bit at 1, the two maps trade places.
- R2: The swap bit is loaded from `swap_i` when `swap_we` is high. A write in the same cycle still uses the old mapping. The new mapping applies from the next cycle. A change of the bit never moves stored data.
- R3: Size code 0 accesses one word. On a read it appears at `rd_data[31:0]`, and the upper bits read 0. On a write it is taken from `wr_data[31:0]`.
- R4: Size code 1 accesses the pair {n, n+1} for an even index n. Register n holds bits [63:32] and register n+1 holds bits [31:0]. On a read, bits [127:64] are 0.
- R5: Size code 2 accesses the group n..n+3 for an index n that is a multiple of 4. Register n holds bits [127:96], n+1 holds [95:64], n+2 holds [63:32] and n+3 holds [31:0].
- R6: A write with size code 3, an odd pair index or a group index that is not a multiple of 4 changes no register. `wr_err_o` is high in the following cycle. After a valid write or no write, `wr_err_o` is low.
- R7: A read with size code 3 or a misaligned index drives `rd_err_o` high in the same cycle, and `rd_data` is all zeros.
- R8: The word at `mtx_o` bits [32k+31:32k] always equals extended register k under the current mapping.
- R9: The transfer register loads `ul_d` when `ul_we` is high. Otherwise it loads `rd_data[31:0]` when `ul_cap` is high. Otherwise it holds its value. The new value is visible in the next cycle.
- R10: After reset, all 32 registers, the swap bit, the transfer register and `wr_err_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| swap_we | input | 1 | Load the swap bit |
| swap_i | input | 1 | New swap bit value |
| bank_swap_o | output | 1 | Current swap bit |
| wr_en | input | 1 | Write request |
| wr_ext | input | 1 | Write set select, 0 front, 1 extended |
| wr_size | input | 2 | Write size code |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 128 | Write data |
| wr_err_o | output | 1 | Previous cycle's write was rejected |
| rd_ext | input | 1 | Read set select |
| rd_size | input | 2 | Read size code |
| rd_idx | input | 4 | Read register index |
| rd_data | output | 128 | Read data |
| rd_err_o | output | 1 | Current read request is invalid |
| mtx_o | output | 512 | Extended set as a matrix, word k = XFk |
| ul_we | input | 1 | Load transfer register from the integer side |
| ul_d | input | 32 | Integer-side data |
| ul_cap | input | 1 | Capture the read port low word into the transfer register |
| ul_q | output | 32 | Transfer register |

## Verification
A word written to the wrong bank, lane or register shows at once in the matrix view when it lands in the extended set. When it lands in the front set, it shows on the next read of that register. The bench compares the full matrix after every cycle and reads a random location every cycle. A swap bit that is updated one cycle late or one cycle early sends the write of the swap cycle to the wrong bank, so the error shows in the very next cycle. A rejected write that still stores data changes the matrix or a later read. A wrong error flag shows in the cycle after the request.

// File: rtl/fpr_pkg.sv
package fpr_pkg;
  typedef enum logic [1:0] {
    FPR_SZ_ONE  = 2'd0,
    FPR_SZ_TWO  = 2'd1,
    FPR_SZ_FOUR = 2'd2,
    FPR_SZ_RSVD = 2'd3
  } fpr_size_e;
endpackage

// File: rtl/fpr_size_decode.sv
module fpr_size_decode
  import fpr_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic [1:0]       size,
  input  logic [IDX_W-1:0] idx,
  output logic             ok,
  output logic [2:0]       cnt
);
  always_comb begin
    case (fpr_size_e'(size))
      FPR_SZ_ONE: begin
        ok  = 1'b1;
        cnt = 3'd1;
      end
      FPR_SZ_TWO: begin
        ok  = ~idx[0];
        cnt = 3'd2;
      end
      FPR_SZ_FOUR: begin
        ok  = (idx[1:0] == 2'b00);
        cnt = 3'd4;
      end
      default: begin
        ok  = 1'b0;
        cnt = 3'd0;
      end
    endcase
  end
endmodule

// File: rtl/fpr_bank.sv
module fpr_bank #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NREG   = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NREG-1:0]              we,
  input  logic [NREG-1:0][WORD_W-1:0]  wd,
  output logic [NREG-1:0][WORD_W-1:0]  q
);
  for (genvar r = 0; r < NREG; r++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q[r] <= '0;
      end else if (we[r]) begin
        q[r] <= wd[r];
      end
    end
  end
endmodule

// File: rtl/fpr_read_port.sv
module fpr_read_port #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NREG   = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned LANES  = 4
) (
  input  logic [NREG-1:0][WORD_W-1:0] bank0_q,
  input  logic [NREG-1:0][WORD_W-1:0] bank1_q,
  input  logic                        ext,
  input  logic                        swap,
  input  logic [1:0]                  size,
  input  logic [IDX_W-1:0]            idx,
  output logic [LANES*WORD_W-1:0]     data,
  output logic                        err
);
  logic       ok;
  logic [2:0] cnt;

  fpr_size_decode #(.IDX_W(IDX_W)) u_dec (
    .size (size),
    .idx  (idx),
    .ok   (ok),
    .cnt  (cnt)
  );

  always_comb begin : rd_route
    logic [IDX_W-1:0] r;
    int               pos;
    data = '0;
    r    = '0;
    pos  = 0;
    if (ok) begin
      for (int j = 0; j < LANES; j++) begin
        if (j < int'(cnt)) begin
          r   = idx + IDX_W'(j);
          pos = int'(cnt) - 1 - j;
          data[pos*WORD_W +: WORD_W] = (ext ^ swap) ? bank1_q[r] : bank0_q[r];
        end
      end
    end
    err = ~ok;
  end
endmodule

// File: rtl/fpr_bank_file.sv
module fpr_bank_file #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NREG   = 16,
  parameter int unsigned LANES  = 4,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned WIDE_W = LANES * WORD_W,
  localparam int unsigned MTX_W = NREG * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              swap_we,
  input  logic              swap_i,
  output logic              bank_swap_o,
  input  logic              wr_en,
  input  logic              wr_ext,
  input  logic [1:0]        wr_size,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WIDE_W-1:0] wr_data,
  output logic              wr_err_o,
  input  logic              rd_ext,
  input  logic [1:0]        rd_size,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WIDE_W-1:0] rd_data,
  output logic              rd_err_o,
  output logic [MTX_W-1:0]  mtx_o,
  input  logic              ul_we,
  input  logic [WORD_W-1:0] ul_d,
  input  logic              ul_cap,
  output logic [WORD_W-1:0] ul_q
);
  logic                        swap_q, swap_nxt;
  logic                        werr_q, werr_nxt;
  logic [WORD_W-1:0]           ul_r, ul_nxt;
  logic                        w_ok;
  logic [2:0]                  w_cnt;
  logic [1:0][NREG-1:0]        bank_we;
  logic [NREG-1:0][WORD_W-1:0] bank_wd;
  logic [NREG-1:0][WORD_W-1:0] b0_q, b1_q;

  fpr_size_decode #(.IDX_W(IDX_W)) u_wdec (
    .size (wr_size),
    .idx  (wr_idx),
    .ok   (w_ok),
    .cnt  (w_cnt)
  );

  // Lane routing: each register gets its lane of wr_data and a write enable
  always_comb begin : wr_route
    logic [IDX_W-1:0] r;
    int               pos;
    bank_we = '0;
    bank_wd = '0;
    r       = '0;
    pos     = 0;
    if (wr_en && w_ok) begin
      for (int j = 0; j < LANES; j++) begin
        if (j < int'(w_cnt)) begin
          r   = wr_idx + IDX_W'(j);
          pos = int'(w_cnt) - 1 - j;
          bank_wd[r] = wr_data[pos*WORD_W +: WORD_W];
          bank_we[wr_ext ^ swap_q][r] = 1'b1;
        end
      end
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    if (b == 0) begin : g_b0
      fpr_bank #(.WORD_W(WORD_W), .NREG(NREG)) u_bank (
        .clk (clk), .rst_n (rst_n), .we (bank_we[b]), .wd (bank_wd), .q (b0_q)
      );
    end else begin : g_b1
      fpr_bank #(.WORD_W(WORD_W), .NREG(NREG)) u_bank (
        .clk (clk), .rst_n (rst_n), .we (bank_we[b]), .wd (bank_wd), .q (b1_q)
      );
    end
  end

  fpr_read_port #(
    .WORD_W (WORD_W), .NREG (NREG), .IDX_W (IDX_W), .LANES (LANES)
  ) u_rport (
    .bank0_q (b0_q),
    .bank1_q (b1_q),
    .ext     (rd_ext),
    .swap    (swap_q),
    .size    (rd_size),
    .idx     (rd_idx),
    .data    (rd_data),
    .err     (rd_err_o)
  );

  for (genvar k = 0; k < NREG; k++) begin : g_mtx
    assign mtx_o[k*WORD_W +: WORD_W] = swap_q ? b0_q[k] : b1_q[k];
  end

  always_comb begin
    swap_nxt = swap_we ? swap_i : swap_q;
    werr_nxt = wr_en & ~w_ok;
    if (ul_we) begin
      ul_nxt = ul_d;
    end else if (ul_cap) begin
      ul_nxt = rd_data[WORD_W-1:0];
    end else begin
      ul_nxt = ul_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      swap_q <= 1'b0;
      werr_q <= 1'b0;
      ul_r   <= '0;
    end else begin
      swap_q <= swap_nxt;
      werr_q <= werr_nxt;
      ul_r   <= ul_nxt;
    end
  end

  assign bank_swap_o = swap_q;
  assign wr_err_o    = werr_q;
  assign ul_q        = ul_r;
endmodule

// File: rtl/fpr_bank_file_chk.sv
module fpr_bank_file_chk #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned NREG   = 16,
  parameter int unsigned LANES  = 4,
  localparam int unsigned IDX_W = $clog2(NREG),
  localparam int unsigned WIDE_W = LANES * WORD_W,
  localparam int unsigned MTX_W = NREG * WORD_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              swap_we,
  input logic              bank_swap_o,
  input logic              wr_en,
  input logic [1:0]        wr_size,
  input logic [IDX_W-1:0]  wr_idx,
  input logic              wr_err_o,
  input logic              rd_ext,
  input logic [1:0]        rd_size,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [WIDE_W-1:0] rd_data,
  input logic              rd_err_o,
  input logic [MTX_W-1:0]  mtx_o,
  input logic              ul_we,
  input logic [WORD_W-1:0] ul_d,
  input logic              ul_cap,
  input logic [WORD_W-1:0] ul_q
);
  // R2
  swap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(swap_we) |-> $stable(bank_swap_o));

  // R6
  bad_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_en) && ($past(wr_size) == 2'd3 ||
                      ($past(wr_size) == 2'd1 && $past(wr_idx[0])) ||
                      ($past(wr_size) == 2'd2 && $past(wr_idx[1:0]) != 2'd0)))
    |-> wr_err_o);

  // R6
  bad_write_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err_o && !$past(swap_we)) |-> $stable(mtx_o));

  // R7
  bad_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_err_o |-> (rd_data == '0));

  // R8
  matrix_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_err_o && rd_ext && rd_size == 2'd0) |->
      (rd_data[WORD_W-1:0] == mtx_o[rd_idx*WORD_W +: WORD_W]));

  // R9
  xfer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(ul_we) && !$past(ul_cap)) |-> $stable(ul_q));

  // R9
  xfer_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ul_we) |-> (ul_q == $past(ul_d)));
endmodule

bind fpr_bank_file fpr_bank_file_chk #(
  .WORD_W (WORD_W), .NREG (NREG), .LANES (LANES)
) u_chk (
  .clk (clk), .rst_n (rst_n), .swap_we (swap_we), .bank_swap_o (bank_swap_o),
  .wr_en (wr_en), .wr_size (wr_size), .wr_idx (wr_idx), .wr_err_o (wr_err_o),
  .rd_ext (rd_ext), .rd_size (rd_size), .rd_idx (rd_idx), .rd_data (rd_data),
  .rd_err_o (rd_err_o), .mtx_o (mtx_o), .ul_we (ul_we), .ul_d (ul_d),
  .ul_cap (ul_cap), .ul_q (ul_q)
);

// File: tb/fpr_bank_file_tb.sv
module fpr_bank_file_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         swap_we, swap_i, bank_swap_o;
  logic         wr_en, wr_ext;
  logic [1:0]   wr_size;
  logic [3:0]   wr_idx;
  logic [127:0] wr_data;
  logic         wr_err_o;
  logic         rd_ext;
  logic [1:0]   rd_size;
  logic [3:0]   rd_idx;
  logic [127:0] rd_data;
  logic         rd_err_o;
  logic [511:0] mtx_o;
  logic         ul_we, ul_cap;
  logic [31:0]  ul_d, ul_q;

  int checks = 0;
  int fails  = 0;

  logic [31:0] m [0:1][0:15];
  logic        m_swap, m_err;
  logic [31:0] m_ul;

  always #4 clk = ~clk;

  fpr_bank_file u_dut (
    .clk (clk), .rst_n (rst_n), .swap_we (swap_we), .swap_i (swap_i),
    .bank_swap_o (bank_swap_o), .wr_en (wr_en), .wr_ext (wr_ext),
    .wr_size (wr_size), .wr_idx (wr_idx), .wr_data (wr_data),
    .wr_err_o (wr_err_o), .rd_ext (rd_ext), .rd_size (rd_size),
    .rd_idx (rd_idx), .rd_data (rd_data), .rd_err_o (rd_err_o),
    .mtx_o (mtx_o), .ul_we (ul_we), .ul_d (ul_d), .ul_cap (ul_cap),
    .ul_q (ul_q)
  );

  task automatic chk(input string req, input logic [511:0] act, input logic [511:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic int sz_cnt(input logic [1:0] sz);
    return (sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : (sz == 2'd2) ? 4 : 0;
  endfunction

  function automatic logic sz_ok(input logic [1:0] sz, input logic [3:0] idx);
    return (sz == 2'd0) || (sz == 2'd1 && !idx[0]) || (sz == 2'd2 && idx[1:0] == 2'b00);
  endfunction

  // returns {err, data}
  function automatic logic [128:0] exp_rd(input logic ext, input logic [1:0] sz, input logic [3:0] idx);
    logic [127:0] d = '0;
    int c = sz_cnt(sz);
    if (!sz_ok(sz, idx)) return {1'b1, 128'd0};
    for (int j = 0; j < c; j++) begin
      logic [3:0] r = idx + 4'(j);
      d[32*(c-1-j) +: 32] = m[ext ^ m_swap][r];
    end
    return {1'b0, d};
  endfunction

  function automatic logic [511:0] exp_mtx();
    logic [511:0] x;
    for (int k = 0; k < 16; k++) x[32*k +: 32] = m[~m_swap][k];
    return x;
  endfunction

  task automatic chk_rd(input string req);
    logic [128:0] e;
    #1;
    e = exp_rd(rd_ext, rd_size, rd_idx);
    chk({req, " data"}, 512'(rd_data), 512'(e[127:0]));
    chk({req, " err"}, 512'(rd_err_o), 512'(e[128]));
  endtask

  task automatic idle();
    swap_we = 0; swap_i = 0; wr_en = 0; wr_ext = 0; wr_size = 0; wr_idx = 0;
    wr_data = '0; ul_we = 0; ul_cap = 0; ul_d = '0;
  endtask

  // apply the model to the current inputs, clock once, compare state ports
  task automatic tick();
    logic [128:0] rv = exp_rd(rd_ext, rd_size, rd_idx);
    logic         bad = wr_en && !sz_ok(wr_size, wr_idx);
    if (wr_en && !bad) begin
      int c = sz_cnt(wr_size);
      for (int j = 0; j < c; j++) begin
        logic [3:0] r = wr_idx + 4'(j);
        m[wr_ext ^ m_swap][r] = wr_data[32*(c-1-j) +: 32];
      end
    end
    if (ul_we) m_ul = ul_d;
    else if (ul_cap) m_ul = rv[31:0];
    if (swap_we) m_swap = swap_i;
    m_err = bad;
    @(posedge clk);
    #2;
    idle();
    chk("R6 wr_err", 512'(wr_err_o), 512'(m_err));
    chk("R2 swap", 512'(bank_swap_o), 512'(m_swap));
    chk("R9 xfer", 512'(ul_q), 512'(m_ul));
    chk("R8 matrix", mtx_o, exp_mtx());
  endtask

  task automatic rd(input logic ext, input logic [1:0] sz, input logic [3:0] idx, input string req);
    rd_ext = ext; rd_size = sz; rd_idx = idx;
    chk_rd(req);
  endtask

  task automatic wr(input logic ext, input logic [1:0] sz, input logic [3:0] idx, input logic [127:0] d);
    wr_en = 1; wr_ext = ext; wr_size = sz; wr_idx = idx; wr_data = d;
    tick();
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    idle();
    rd_ext = 0; rd_size = 0; rd_idx = 0;
    for (int b = 0; b < 2; b++) for (int k = 0; k < 16; k++) m[b][k] = '0;
    m_swap = 0; m_ul = '0; m_err = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    #1;
    // R10 reset state
    chk("R10 swap", 512'(bank_swap_o), 512'd0);
    chk("R10 xfer", 512'(ul_q), 512'd0);
    chk("R10 wr_err", 512'(wr_err_o), 512'd0);
    chk("R10 matrix", mtx_o, 512'd0);
    for (int k = 0; k < 16; k++) rd(1'b0, 2'd0, 4'(k), "R10 front");

    // R3 R1 single word, bank mapping
    wr(1'b0, 2'd0, 4'd3, 128'hAAAA_0003);
    rd(1'b0, 2'd0, 4'd3, "R3 single");
    rd(1'b1, 2'd0, 4'd3, "R1 other set");
    wr(1'b1, 2'd0, 4'd3, 128'hBBBB_0003);
    // R2 write in swap cycle uses old mapping; data does not move
    swap_we = 1; swap_i = 1;
    wr(1'b0, 2'd0, 4'd5, 128'hCCCC_0005);
    rd(1'b1, 2'd0, 4'd5, "R2 old map write");
    rd(1'b0, 2'd0, 4'd3, "R2 front after swap");
    rd(1'b1, 2'd0, 4'd3, "R1 ext after swap");
    swap_we = 1; swap_i = 0; tick();
    // R4 pair
    wr(1'b0, 2'd1, 4'd2, 128'h1111_2222_3333_4444_0000_00E0_0000_00E1);
    rd(1'b0, 2'd0, 4'd2, "R4 even upper");
    rd(1'b0, 2'd0, 4'd3, "R4 odd lower");
    rd(1'b0, 2'd1, 4'd2, "R4 pair read");
    // R5 quad
    wr(1'b1, 2'd2, 4'd8, 128'h0000_0A08_0000_0A09_0000_0A0A_0000_0A0B);
    rd(1'b1, 2'd0, 4'd8, "R5 first lane");
    rd(1'b1, 2'd0, 4'd11, "R5 last lane");
    rd(1'b1, 2'd2, 4'd8, "R5 quad read");
    // R6 rejected writes
    wr(1'b1, 2'd2, 4'd6, '1);
    wr(1'b0, 2'd1, 4'd7, '1);
    wr(1'b1, 2'd3, 4'd0, '1);
    for (int k = 0; k < 16; k++) rd(1'b0, 2'd0, 4'(k), "R6 front unchanged");
    // R7 invalid reads
    rd(1'b0, 2'd1, 4'd3, "R7 odd pair");
    rd(1'b1, 2'd2, 4'd2, "R7 bad quad");
    rd(1'b0, 2'd3, 4'd0, "R7 reserved");
    // R9 transfer register
    ul_we = 1; ul_d = 32'hDEAD_BEEF; tick();
    rd_ext = 0; rd_size = 0; rd_idx = 4'd5; ul_cap = 1; tick();
    ul_we = 1; ul_cap = 1; ul_d = 32'h0123_4567; tick();

    // random traffic
    for (int it = 0; it < 3000; it++) begin
      logic [31:0] sel = $urandom;
      wr_en = sel[0]; wr_ext = sel[1]; wr_size = sel[3:2]; wr_idx = sel[7:4];
      wr_data = {$urandom, $urandom, $urandom, $urandom};
      swap_we = (sel[11:8] == 0); swap_i = sel[12];
      ul_we = (sel[15:13] == 0); ul_d = $urandom; ul_cap = (sel[18:16] == 0);
      rd_ext = sel[19]; rd_size = sel[21:20]; rd_idx = sel[25:22];
      chk_rd("R3 R4 R5 R7 random read");
      tick();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule